// File: doc/BRIEF.md
# Masked Eight-Column Block-Write Memory

A synchronous memory array of 16-bit words, organized as rows of columns. Besides the usual single-word write, it has a block-write command. That command paints one shared 16-bit color value into up to eight adjacent columns of a row in a single clock edge. The columns are an aligned group, and each byte lane decides for itself which of the eight columns are touched. A write-mask register protects individual bit positions in every column. Two byte-lane enables gate the lower and upper halves of the word.

In a block-write cycle the data bus does not carry pixel data. It carries a column mask: bit k enables group column k for the lower byte, and bit 8+k enables group column k for the upper byte. The color and write-mask registers are loaded from the data bus by their own strobes beforehand. Reads are registered and return one word per request.

Top module: `blkwr_vram`

## Requirements
- R1: In reset, the whole array is cleared to zero, `rd_data` is 0, the color register is 0 and the write-mask register is 0xFFFF (all bits writable).
- R2: When `color_load` is high, the color register takes `dq_in` at that clock edge. `color_load` wins over `mask_load` and `wr_en` in the same cycle; they then have no effect.
- R3: When `mask_load` is high and `color_load` is low, the write-mask register takes `dq_in`. `wr_en` in the same cycle has no effect.
- R4: A normal write (`wr_en`=1, `blk_sel`=0, no load strobe) updates only the word at {`row_addr`,`col_addr`}. Bit b takes `dq_in[b]` when write-mask bit b is 1 and its lane is enabled. `lane_lo` enables bits 7:0 and `lane_hi` enables bits 15:8.
- R5: A block write (`wr_en`=1, `blk_sel`=1, no load strobe) ignores `col_addr[2:0]`. It acts on the eight columns whose address is `col_addr` with its three low bits cleared, in the addressed row.
- R6: In a block write, `dq_in[k]` enables group column k in the lower byte and `dq_in[8+k]` enables it in the upper byte, for k = 0..7. An enabled lane bit takes the color-register bit. A lane whose column-mask bit is 0 keeps its previous contents.
- R7: A write-mask bit of 0 leaves that bit unchanged in every column, for both write kinds.
- R8: `lane_lo`=0 leaves bits 7:0 of all eight group columns unchanged during a block write, and `lane_hi`=0 does the same for bits 15:8.
- R9: `rd_en` samples the address, and the addressed word appears on `rd_data` after the next clock edge. A write in the same cycle is not yet visible. A read in the cycle after a write sees the new data. `rd_data` holds while `rd_en` is low.
- R10: The following block write lands on an all-zero row. Color 0xE3DD, write mask 0xDFF7, column mask 0x5E0F, column address with low bits 3. Group columns 0..7 then read 0x00D5, 0xC3D5, 0xC3D5, 0xC3D5, 0xC300, 0x0000, 0xC300, 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| row_addr | input | ROW_W | Row address |
| col_addr | input | COL_W | Column address (low 3 bits ignored in block write) |
| dq_in | input | 16 | Write data, column mask or register load value |
| color_load | input | 1 | Load color register from dq_in |
| mask_load | input | 1 | Load write-mask register from dq_in |
| wr_en | input | 1 | Write command |
| blk_sel | input | 1 | 1 selects block write, 0 normal write |
| lane_lo | input | 1 | Enable lower byte (bits 7:0) |
| lane_hi | input | 1 | Enable upper byte (bits 15:8) |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Registered read data |

## Verification
The hardest situation to reach is a block write in which the two byte lanes disagree. The lower and upper column masks select different columns, and a partial write mask and one disabled lane cut across both. Errors there only show when every column of the group is read back. The stimulus drives long runs of pseudo-random block writes with independent column masks, byte enables, write masks and low column bits. A behavioural model checks every read in the bench. Sweeps that read back whole rows follow these runs, and the worked pattern is checked against fixed values on a fresh row.

// File: rtl/blkwr_vram.sv
module blkwr_vram #(
  parameter int ROW_W = 3,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  input  logic [15:0]      dq_in,
  input  logic             color_load,
  input  logic             mask_load,
  input  logic             wr_en,
  input  logic             blk_sel,
  input  logic             lane_lo,
  input  logic             lane_hi,
  input  logic             rd_en,
  output logic [15:0]      rd_data
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int GRP    = 8;

  logic [15:0] mem [DEPTH];
  logic [15:0] color_q, wmask_q;

  wire [ADDR_W-1:0] addr     = {row_addr, col_addr};
  wire [ADDR_W-1:0] grp_base = addr & ~ADDR_W'(GRP - 1);
  wire [15:0]       lane_en  = {{8{lane_hi}}, {8{lane_lo}}};
  wire              do_write = wr_en && !color_load && !mask_load;

  function automatic logic [15:0] merge(input logic [15:0] old_w,
                                        input logic [15:0] new_w,
                                        input logic [15:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      color_q <= '0;
      wmask_q <= '1;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[addr];
      if (color_load) color_q <= dq_in;
      else if (mask_load) wmask_q <= dq_in;
      if (do_write) begin
        if (!blk_sel) begin
          mem[addr] <= merge(mem[addr], dq_in, wmask_q & lane_en);
        end else begin
          for (int k = 0; k < GRP; k++) begin
            mem[grp_base | ADDR_W'(k)] <= merge(mem[grp_base | ADDR_W'(k)], color_q,
              wmask_q & lane_en & {{8{dq_in[8+k]}}, {8{dq_in[k]}}});
          end
        end
      end
    end
  end

  AST_COLOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    color_load |=> color_q == $past(dq_in)); // R2
  AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !color_load |=> $stable(color_q)); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_load && !color_load |=> wmask_q == $past(dq_in)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_load && !color_load) |=> $stable(wmask_q)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: tb/blkwr_vram_test.sv
module blkwr_vram_test;
  localparam int ROW_W = 3, COL_W = 5, DEPTH = 1 << (ROW_W + COL_W);

  logic clk = 0, rst_n = 0;
  logic [ROW_W-1:0] row_addr = 0;
  logic [COL_W-1:0] col_addr = 0;
  logic [15:0] dq_in = 0;
  logic color_load = 0, mask_load = 0, wr_en = 0, blk_sel = 0;
  logic lane_lo = 0, lane_hi = 0, rd_en = 0;
  logic [15:0] rd_data;

  blkwr_vram #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  int ref_mem [DEPTH];
  int ref_color, ref_mask, exp_rd;

  always @(posedge clk) begin
    int a, base;
    a = {row_addr, col_addr};
    if (!rst_n) begin
      foreach (ref_mem[i]) ref_mem[i] = 0;
      ref_color = 0; ref_mask = 16'hFFFF; exp_rd = 0;
    end else begin
      if (rd_en) exp_rd = ref_mem[a];
      if (color_load) ref_color = dq_in;
      else if (mask_load) ref_mask = dq_in;
      else if (wr_en) begin
        if (!blk_sel) begin
          for (int b = 0; b < 16; b++)
            if (ref_mask[b] && (b < 8 ? lane_lo : lane_hi))
              ref_mem[a][b] = dq_in[b];
        end else begin
          base = a - (a % 8);
          for (int c = 0; c < 8; c++)
            for (int b = 0; b < 16; b++)
              if (ref_mask[b] && (b < 8 ? (lane_lo && dq_in[c]) : (lane_hi && dq_in[8+c])))
                ref_mem[base+c][b] = ref_color[b];
        end
      end
    end
  end

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check(rd_data, exp_rd[15:0], cur_req);

  task automatic step(input logic cl, ml, we, bs, lo, hi, re,
                      input int r, c, d);
    color_load = cl; mask_load = ml; wr_en = we; blk_sel = bs;
    lane_lo = lo; lane_hi = hi; rd_en = re;
    row_addr = ROW_W'(r); col_addr = COL_W'(c); dq_in = 16'(d);
    @(negedge clk);
    color_load = 0; mask_load = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(input int r, c);
    step(0,0,0,0,0,0,1, r, c, 0);
  endtask

  task automatic sweep_row(input int r);
    for (int c = 0; c < (1 << COL_W); c++) rd(r, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd(0, 0); check(rd_data, 16'h0000, "R1");
    rd(7, 31); check(rd_data, 16'h0000, "R1");
    step(0,0,1,0,1,1,0, 1, 2, 16'hA55A);
    rd(1, 2); check(rd_data, 16'hA55A, "R1 mask all ones");

    cur_req = "R2";
    step(1,1,1,1,1,1,0, 1, 0, 16'h1234);
    rd(1, 0); check(rd_data, 16'h0000, "R2 load beats write");
    step(0,0,1,1,1,1,0, 1, 0, 16'h0101);
    rd(1, 0); check(rd_data, 16'h1234, "R2 color");

    cur_req = "R3";
    step(0,1,1,0,1,1,0, 2, 0, 16'h0FF0);
    rd(2, 0); check(rd_data, 16'h0000, "R3 load beats write");
    step(0,0,1,0,1,1,0, 2, 0, 16'hFFFF);
    rd(2, 0); check(rd_data, 16'h0FF0, "R3 mask");

    cur_req = "R4";
    step(0,1,0,0,0,0,0, 0, 0, 16'hFFFF);
    step(0,0,1,0,1,0,0, 2, 1, 16'hBEEF);
    rd(2, 1); check(rd_data, 16'h00EF, "R4 lane_lo only");
    step(0,0,1,0,0,1,0, 2, 1, 16'hCAFE);
    rd(2, 1); check(rd_data, 16'hCAEF, "R4 lane_hi only");

    cur_req = "R9";
    step(0,0,1,0,1,1,1, 2, 1, 16'h7777);
    check(rd_data, 16'hCAEF, "R9 same cycle old data");
    rd(2, 1); check(rd_data, 16'h7777, "R9 next cycle new data");

    cur_req = "R10";
    step(1,0,0,0,0,0,0, 0, 0, 16'hE3DD);
    step(0,1,0,0,0,0,0, 0, 0, 16'hDFF7);
    step(0,0,1,1,1,1,0, 5, 3, 16'h5E0F);
    begin
      logic [15:0] pat [8] = '{16'h00D5, 16'hC3D5, 16'hC3D5, 16'hC3D5,
                               16'hC300, 16'h0000, 16'hC300, 16'h0000};
      for (int c = 0; c < 8; c++) begin
        rd(5, c); check(rd_data, pat[c], "R10");
      end
      rd(5, 8); check(rd_data, 16'h0000, "R5 outside group");
    end

    cur_req = "R8";
    step(0,1,0,0,0,0,0, 0, 0, 16'hFFFF);
    step(1,0,0,0,0,0,0, 0, 0, 16'hFFFF);
    step(0,0,1,1,0,1,0, 6, 13, 16'hFFFF);
    rd(6, 8); check(rd_data, 16'hFF00, "R8 lower lane off");
    rd(6, 15); check(rd_data, 16'hFF00, "R5 R8 aligned group");

    cur_req = "R6";
    for (int n = 0; n < 3000; n++) begin
      int r, c, d, kind;
      kind = $urandom_range(0, 9);
      r = $urandom_range(0, 7); c = $urandom_range(0, 31); d = $urandom();
      cur_req = (n % 2) ? "R6" : "R7";
      case (kind)
        0: step(1,0,0,0,0,0,0, r, c, d);
        1: step(0,1,0,0,0,0,0, r, c, d);
        2, 3: step(0,0,1,0,$urandom_range(0,1),$urandom_range(0,1),$urandom_range(0,1), r, c, d);
        default: step(0,0,1,1,$urandom_range(0,1),$urandom_range(0,1),$urandom_range(0,1), r, c, d);
      endcase
    end
    cur_req = "R5";
    for (int r = 0; r < 8; r++) sweep_row(r);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule